// File: doc/BRIEF.md
# SPI Command Transmit Engine

This block is the transmit-only side path of an SPI master. It sends a short command of one to four bytes without going through any FIFO. Software loads the command word into a 32-bit register. It programs the byte count, bit order, word width and clock divider in a control register, then writes a go strobe. The engine lowers chip select and shifts the command out on MOSI in SPI mode 0. Nothing is captured from the slave. When the frame is over, the engine raises chip select and sets a frame-end status flag, which can drive an interrupt line.

The register port is a plain single-cycle write bus with combinational read data. The map is: control at 0, command at 1, interrupt enable at 2, status at 3, go at 4. Control bits are: bit 0 command-mode enable; bits [2:1] byte count minus one; bit 3 LSB-first; bit 4 16-bit words; bits [15:8] clock divider. Status bit 0 is the frame-end flag and status bit 1 reads back busy. Interrupt-enable bit 0 gates the frame-end flag onto the interrupt line.

Top module: `spi_cmd_tx`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, busy_o and irq_o are 0, and every register reads back 0.
- R2: A go write (address 4, data bit 0 set) while control bit 0 is clear is ignored: chip select stays high and busy stays low.
- R3: In 8-bit mode a frame carries exactly 8*(count+1) SCK pulses, where count is control bits [2:1].
- R4: In 8-bit MSB-first mode the first byte sent is command bits [8*count+7:8*count] and the last is bits [7:0]; each byte goes out MSB first.
- R5: In 16-bit MSB-first mode with count 3, command bits [31:16] go out first and then bits [15:0], each halfword MSB first.
- R6: In 16-bit mode the low bit of count is treated as 1, so a frame always carries whole halfwords: count 0 sends 16 bits and count 2 sends 32 bits.
- R7: In LSB-first mode (control bit 3) bits go out in ascending order from command bit 0, each byte LSB first.
- R8: SCK is low whenever chip select is high. Every SCK edge falls on a multiple of H = divider+1 clocks from the go edge. MOSI does not change while SCK is high.
- R9: Chip select falls on the go edge and SCK first rises H clocks later. Chip select rises (2N+1)*H clocks after the go edge, where N is the bit count. busy_o is high exactly while chip select is low.
- R10: The edge that raises chip select sets status bit 0. irq_o is high while both status bit 0 and interrupt-enable bit 0 are set.
- R11: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R12: A go write during a frame is ignored. The running frame keeps its length and content, and no new frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register word address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| sck_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | Serial data out |
| cs_no | output | 1 | Chip select, active low |
| busy_o | output | 1 | Frame in progress |
| irq_o | output | 1 | Frame-end interrupt |

## Verification
All timing is counted from the clock edge that samples the go write. Chip select and busy change on that edge, and SCK rises H clocks after it. Each later SCK edge follows the previous one by H clocks. Chip select rises and the status flag sets together, (2N+1)*H clocks after the go edge. The bench drives on falling clock edges and counts falling edges from the go edge. It records MOSI wherever SCK has just risen, and checks each of these cycle numbers exactly against values computed from the divider and the bit count. Register reads and the interrupt line are sampled only after the frame has closed.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMD  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_IEN  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_STAT = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_GO   = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } shift_state_e;
endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned CNT_W = 2,
  parameter int unsigned DIV_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic                  we_i,
  input  logic [CMD_W-1:0]      wdata_i,
  output logic [CMD_W-1:0]      rdata_o,
  input  logic                  frame_end_i,
  input  logic                  busy_i,
  output logic                  en_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  lsb_o,
  output logic                  wide_o,
  output logic [DIV_W-1:0]      div_o,
  output logic [CMD_W-1:0]      cmd_o,
  output logic                  fe_stat_o,
  output logic                  irq_o,
  output logic                  go_o
);
  localparam int unsigned LSB_BIT  = CNT_W + 1;
  localparam int unsigned WIDE_BIT = CNT_W + 2;
  localparam int unsigned DIV_LO   = 8;

  logic en_q, lsb_q, wide_q, ien_q, fe_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic [CMD_W-1:0] cmd_q;

  logic wr_ctrl, wr_cmd, wr_ien, wr_stat, wr_go;
  assign wr_ctrl = we_i && (addr_i == ADDR_CTRL);
  assign wr_cmd  = we_i && (addr_i == ADDR_CMD);
  assign wr_ien  = we_i && (addr_i == ADDR_IEN);
  assign wr_stat = we_i && (addr_i == ADDR_STAT);
  assign wr_go   = we_i && (addr_i == ADDR_GO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cnt_q  <= '0;
      lsb_q  <= 1'b0;
      wide_q <= 1'b0;
      div_q  <= '0;
      cmd_q  <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[0];
        cnt_q  <= wdata_i[CNT_W:1];
        lsb_q  <= wdata_i[LSB_BIT];
        wide_q <= wdata_i[WIDE_BIT];
        div_q  <= wdata_i[DIV_LO +: DIV_W];
      end
      if (wr_cmd) cmd_q <= wdata_i;
      if (wr_ien) ien_q <= wdata_i[0];
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      fe_q <= 1'b0;
    else if (frame_end_i)             fe_q <= 1'b1;
    else if (wr_stat && wdata_i[0])   fe_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[0]              = en_q;
        rdata_o[CNT_W:1]        = cnt_q;
        rdata_o[LSB_BIT]        = lsb_q;
        rdata_o[WIDE_BIT]       = wide_q;
        rdata_o[DIV_LO +: DIV_W] = div_q;
      end
      ADDR_CMD:  rdata_o = cmd_q;
      ADDR_IEN:  rdata_o[0] = ien_q;
      ADDR_STAT: begin
        rdata_o[0] = fe_q;
        rdata_o[1] = busy_i;
      end
      default:   rdata_o = '0;
    endcase
  end

  assign en_o      = en_q;
  assign cnt_o     = cnt_q;
  assign lsb_o     = lsb_q;
  assign wide_o    = wide_q;
  assign div_o     = div_q;
  assign cmd_o     = cmd_q;
  assign fe_stat_o = fe_q;
  assign irq_o     = fe_q && ien_q;
  assign go_o      = wr_go && wdata_i[0] && en_q;
endmodule

// File: rtl/spi_cmd_order.sv
module spi_cmd_order #(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned CNT_W = 2,
  parameter int unsigned BIT_W = 6
) (
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             lsb_i,
  input  logic             wide_i,
  output logic [CMD_W-1:0] seq_o,
  output logic [BIT_W-1:0] nbits_o
);
  logic [CNT_W-1:0] cnt_eff;
  logic [CNT_W:0]   nbytes;
  logic [CMD_W-1:0] rev;
  logic [CMD_W-1:0] msb_seq;

  // halfword mode always sends an even byte count
  assign cnt_eff = wide_i ? (cnt_i | CNT_W'(1)) : cnt_i;
  assign nbytes  = {1'b0, cnt_eff} + (CNT_W+1)'(1);
  assign nbits_o = BIT_W'({nbytes, 3'b000});

  for (genvar g = 0; g < CMD_W; g++) begin : g_rev
    assign rev[g] = cmd_i[CMD_W-1-g];
  end

  // right-justified command moved up so its first bit lands on the MSB
  assign msb_seq = cmd_i << (CMD_W - int'(nbits_o));
  assign seq_o   = lsb_i ? rev : msb_seq;
endmodule

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] hcnt_q;

  assign tick_o = run_i && (hcnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hcnt_q <= '0;
    else if (!run_i) hcnt_q <= '0;
    else if (tick_o) hcnt_q <= '0;
    else             hcnt_q <= hcnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned BIT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CMD_W-1:0] seq_i,
  input  logic [BIT_W-1:0] nbits_i,
  input  logic             tick_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             cs_no,
  output logic             busy_o,
  output logic             frame_end_o
);
  shift_state_e     state_q;
  logic [CMD_W-1:0] sh_q;
  logic [BIT_W-1:0] left_q;
  logic             sck_q, cs_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      sck_q   <= 1'b0;
      cs_nq   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sh_q    <= seq_i;
            left_q  <= nbits_i;
            sck_q   <= 1'b0;
            cs_nq   <= 1'b0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
            end else begin
              sck_q <= 1'b0;
              if (left_q == BIT_W'(1)) begin
                state_q <= ST_TAIL;
              end else begin
                sh_q   <= sh_q << 1;
                left_q <= left_q - BIT_W'(1);
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick_i) begin
            cs_nq   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o       = sck_q;
  assign mosi_o      = sh_q[CMD_W-1];
  assign cs_no       = cs_nq;
  assign busy_o      = (state_q != ST_IDLE);
  assign frame_end_o = (state_q == ST_TAIL) && tick_i;
endmodule

// File: rtl/spi_cmd_tx.sv
module spi_cmd_tx
  import spi_cmd_pkg::*;
#(
  parameter int unsigned CMD_BYTES = 4,
  parameter int unsigned DIV_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic                  reg_we_i,
  input  logic [8*CMD_BYTES-1:0] reg_wdata_i,
  output logic [8*CMD_BYTES-1:0] reg_rdata_o,
  output logic                  sck_o,
  output logic                  mosi_o,
  output logic                  cs_no,
  output logic                  busy_o,
  output logic                  irq_o
);
  localparam int unsigned CMD_W = 8 * CMD_BYTES;
  localparam int unsigned CNT_W = $clog2(CMD_BYTES);
  localparam int unsigned BIT_W = $clog2(CMD_W + 1);

  logic             cfg_en, cfg_lsb, cfg_wide;
  logic [CNT_W-1:0] cfg_cnt;
  logic [DIV_W-1:0] cfg_div;
  logic [CMD_W-1:0] cmd_word, seq;
  logic [BIT_W-1:0] nbits;
  logic             fe_stat, frame_end, go, tick, busy;

  spi_cmd_regs #(.CMD_W(CMD_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (reg_addr_i),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .frame_end_i (frame_end),
    .busy_i      (busy),
    .en_o        (cfg_en),
    .cnt_o       (cfg_cnt),
    .lsb_o       (cfg_lsb),
    .wide_o      (cfg_wide),
    .div_o       (cfg_div),
    .cmd_o       (cmd_word),
    .fe_stat_o   (fe_stat),
    .irq_o       (irq_o),
    .go_o        (go)
  );

  spi_cmd_order #(.CMD_W(CMD_W), .CNT_W(CNT_W), .BIT_W(BIT_W)) u_order (
    .cmd_i   (cmd_word),
    .cnt_i   (cfg_cnt),
    .lsb_i   (cfg_lsb),
    .wide_i  (cfg_wide),
    .seq_o   (seq),
    .nbits_o (nbits)
  );

  spi_cmd_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .div_i  (cfg_div),
    .tick_o (tick)
  );

  spi_cmd_shift #(.CMD_W(CMD_W), .BIT_W(BIT_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (go),
    .seq_i       (seq),
    .nbits_i     (nbits),
    .tick_i      (tick),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .cs_no       (cs_no),
    .busy_o      (busy),
    .frame_end_o (frame_end)
  );

  assign busy_o = busy;
endmodule

// File: rtl/spi_cmd_tx_sva.sv
module spi_cmd_tx_sva
  import spi_cmd_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [REG_ADDR_W-1:0] reg_addr_i,
  input logic                  reg_we_i,
  input logic                  wdata0_i,
  input logic                  sck_o,
  input logic                  mosi_o,
  input logic                  cs_no,
  input logic                  busy_o,
  input logic                  cfg_en_i,
  input logic                  fe_stat_i,
  input logic                  frame_end_i
);
  a_r8_sck_low_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  a_r8_mosi_held_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> $stable(mosi_o));

  a_r9_busy_covers_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);

  a_r10_end_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> fe_stat_i);

  a_r12_select_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(!busy_o));

  a_r2_go_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_GO && !cfg_en_i && !busy_o) |=> !busy_o);

  a_r11_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_STAT && wdata0_i && !frame_end_i) |=> !fe_stat_i);
endmodule

bind spi_cmd_tx spi_cmd_tx_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_we_i    (reg_we_i),
  .wdata0_i    (reg_wdata_i[0]),
  .sck_o       (sck_o),
  .mosi_o      (mosi_o),
  .cs_no       (cs_no),
  .busy_o      (busy_o),
  .cfg_en_i    (cfg_en),
  .fe_stat_i   (fe_stat),
  .frame_end_i (frame_end)
);

// File: tb/spi_cmd_tx_tb.sv
`timescale 1ns/1ps
module spi_cmd_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, cs_n, busy, irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  spi_cmd_tx u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_addr_i  (addr),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .sck_o       (sck),
    .mosi_o      (mosi),
    .cs_no       (cs_n),
    .busy_o      (busy),
    .irq_o       (irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input int cnt, input bit lsb,
                                          input bit wide, input int dv);
    logic [31:0] c;
    c = '0;
    c[0] = en; c[2:1] = cnt[1:0]; c[3] = lsb; c[4] = wide; c[15:8] = dv[7:0];
    return c;
  endfunction

  // expected send order: bit k of seq is the k-th bit on the wire
  task automatic build_exp(input logic [31:0] cmd, input int cnt, input bit lsb,
                           input bit wide, output logic [31:0] seq, output int n);
    int nb;
    logic [15:0] hw;
    logic [7:0]  by;
    nb = wide ? ((cnt | 1) + 1) : (cnt + 1);
    n = nb * 8;
    seq = '0;
    if (lsb) begin
      for (int k = 0; k < n; k++) seq[k] = cmd[k];
    end else if (wide) begin
      for (int h = 0; h < nb/2; h++) begin
        hw = cmd[16*(nb/2-1-h) +: 16];
        for (int b = 0; b < 16; b++) seq[16*h+b] = hw[15-b];
      end
    end else begin
      for (int i = 0; i < nb; i++) begin
        by = cmd[8*(nb-1-i) +: 8];
        for (int b = 0; b < 8; b++) seq[8*i+b] = by[7-b];
      end
    end
  endtask

  task automatic run_frame(input logic [31:0] cmd, input int cnt, input bit lsb,
                           input bit wide, input int dv, input int inject, input string tag);
    logic [31:0] exp_seq, got, st;
    int n, h, j, rises, first_rise, cs_up, bad_time, bad_hold, bad_busy;
    bit busy_end, prev_sck, prev_mosi;
    h = dv + 1;
    build_exp(cmd, cnt, lsb, wide, exp_seq, n);
    wr(3'd1, cmd);
    wr(3'd0, mk_ctrl(1'b1, cnt, lsb, wide, dv));
    wr(3'd4, 32'd1);
    j = 0; rises = 0; got = '0; first_rise = -1; cs_up = -1;
    bad_time = 0; bad_hold = 0; bad_busy = 0; busy_end = 1'b1;
    chk(cs_n == 1'b0 && busy == 1'b1, {"R9 select on go edge ", tag}, {cs_n, busy}, 2'b01);
    prev_sck = sck; prev_mosi = mosi;
    while (j < 1000 && cs_up < 0) begin
      @(negedge clk); j++;
      if (j == inject) begin addr = 3'd4; wdata = 32'd1; we = 1'b1; end
      else if (j == inject + 1) we = 1'b0;
      if (sck != prev_sck) begin
        if (j % h != 0) bad_time++;
        if (sck) begin
          if (rises < 32) got[rises] = mosi;
          if (first_rise < 0) first_rise = j;
          rises++;
        end
      end
      if (sck && prev_sck && mosi != prev_mosi) bad_hold++;
      if (cs_n && sck) bad_time++;
      if (!cs_n && !busy) bad_busy++;
      if (cs_n) begin cs_up = j; busy_end = busy; end
      prev_sck = sck; prev_mosi = mosi;
    end
    we = 1'b0;
    chk(rises == n, {"R3/R6 pulse count ", tag}, rises, n);
    chk(got == exp_seq, {"R4/R5/R7 bit order ", tag}, got, exp_seq);
    chk(first_rise == h, {"R9 first rise ", tag}, first_rise, h);
    chk(cs_up == (2*n+1)*h, {"R9 deselect cycle ", tag}, cs_up, (2*n+1)*h);
    chk(bad_time == 0 && bad_hold == 0, {"R8 edge timing ", tag}, bad_time + bad_hold, 0);
    chk(bad_busy == 0 && busy_end == 1'b0, {"R9 busy span ", tag}, bad_busy + busy_end, 0);
    rd(3'd3, st);
    chk(st[0] == 1'b1, {"R10 frame-end flag ", tag}, st[0], 1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk(cs_n && !sck && !busy && !irq, "R1 outputs after reset", {cs_n, sck, busy, irq}, 4'b1000);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk(v == 32'd0, "R1 register reads zero", v, 0);
    end
  endtask

  task automatic t_disabled();
    int seen;
    seen = 0;
    wr(3'd1, 32'hFF);
    wr(3'd0, mk_ctrl(1'b0, 0, 1'b0, 1'b0, 0));
    wr(3'd4, 32'd1);
    for (int i = 0; i < 20; i++) begin
      if (!cs_n || busy || sck) seen++;
      @(negedge clk);
    end
    chk(seen == 0, "R2 go ignored while disabled", seen, 0);
  endtask

  task automatic t_frames_8bit();
    run_frame(32'h0000_00A5, 0, 1'b0, 1'b0, 0, -5, "msb8 1B");
    wr(3'd3, 32'd1);
    run_frame(32'h00C3_5A96, 2, 1'b0, 1'b0, 2, -5, "msb8 3B");
    wr(3'd3, 32'd1);
    run_frame(32'h8142_24F0, 3, 1'b0, 1'b0, 1, -5, "msb8 4B");
    wr(3'd3, 32'd1);
  endtask

  task automatic t_frames_16bit();
    run_frame(32'h1234_ABCD, 3, 1'b0, 1'b1, 1, -5, "msb16 4B");
    wr(3'd3, 32'd1);
    run_frame(32'h0000_BEEF, 0, 1'b0, 1'b1, 0, -5, "msb16 count0 rounds");
    wr(3'd3, 32'd1);
  endtask

  task automatic t_frames_lsb();
    run_frame(32'h0000_3C81, 1, 1'b1, 1'b0, 0, -5, "lsb8 2B");
    wr(3'd3, 32'd1);
    run_frame(32'hC001_D00D, 2, 1'b1, 1'b1, 1, -5, "lsb16 count2 rounds");
    wr(3'd3, 32'd1);
  endtask

  task automatic t_irq();
    logic [31:0] st;
    wr(3'd2, 32'd0);
    run_frame(32'h0000_0055, 0, 1'b0, 1'b0, 0, -5, "irq masked");
    chk(irq == 1'b0, "R10 irq masked by enable", irq, 0);
    wr(3'd3, 32'd0);
    rd(3'd3, st);
    chk(st[0] == 1'b1, "R11 writing 0 keeps flag", st[0], 1);
    wr(3'd2, 32'd1);
    #1;
    chk(irq == 1'b1, "R10 irq when enabled and flagged", irq, 1);
    wr(3'd3, 32'd1);
    rd(3'd3, st);
    chk(st[0] == 1'b0 && irq == 1'b0, "R11 write 1 clears flag", {st[0], irq}, 0);
    wr(3'd2, 32'd0);
  endtask

  task automatic t_go_while_busy();
    int seen;
    seen = 0;
    run_frame(32'h0000_00E7, 0, 1'b0, 1'b0, 0, 5, "R12 go during frame");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!cs_n || busy) seen++;
    end
    chk(seen == 0, "R12 no frame after ignored go", seen, 0);
    wr(3'd3, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_frames_8bit();
    t_frames_16bit();
    t_frames_lsb();
    t_irq();
    t_go_while_busy();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule